// File: doc/BRIEF.md
# Parallel Two-Way Merge Node

This block is one node of a hardware merge tree. It takes two key streams that are each already in ascending order, delivered as blocks of W keys, and produces one ascending stream that carries W keys per output beat. Both sides keep a small staging register of 2W keys. Each iteration compares left entry x against right entry W-1-x for every x. The smaller key of each pair is one of the W smallest pending keys overall. Each side then shifts down by the number of keys it gave up.

The W winners need not split evenly between the sides, so they pass through a full W-input sorting network before they are registered onto the output. A side accepts a new input block whenever it holds at most W pending keys. Each input stream marks its final block with a last flag. Once a side is finished, its empty slots act as keys larger than any real key and are never emitted. The final output beat carries a last flag, and the node is then ready to start the next merge. Every input stream must hold at least one full block.

Top module: `merge_node`

## Requirements
- R1: After reset, the output is not valid and both input sides are ready.
- R2: A side is ready only while it has not seen its last block and holds at most W pending keys. With the output stalled, a side accepts exactly two blocks back to back, its ready then drops, and it holds at least W keys after any accepted block.
- R3: No output beat is produced while one side is unfinished and holds fewer than W pending keys.
- R4: Inside each output beat the keys ascend with the lane index. Lane i occupies bits [i*KW +: KW], and lane 0 holds the smallest key. Input blocks use the same lane layout.
- R5: The concatenation of all output beats of one merge equals the ascending merge of both input streams. This holds for interleaved keys, for keys where one side lies wholly below the other, for duplicate keys, and for streams of unequal length.
- R6: Every output beat carries W real keys. Empty slots are never emitted, even when real keys equal the all-ones maximum value, and the number of keys out equals the number in.
- R7: The last flag is set on the final beat of a merge and on no other beat. After that beat's iteration, no pending key remains on either side.
- R8: While the output is valid and not ready, the output data and last flag hold steady, and no key is lost.
- R9: Once the final beat has been computed, both inputs become ready again, and a following merge is output without keys from the earlier one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| a_valid | input | 1 | Left block valid |
| a_ready | output | 1 | Left block accepted on this edge when valid |
| a_data | input | W*KW | Left block, W ascending keys, lane 0 smallest |
| a_last | input | 1 | Left block is the final one of its stream |
| b_valid | input | 1 | Right block valid |
| b_ready | output | 1 | Right block accepted on this edge when valid |
| b_data | input | W*KW | Right block, W ascending keys, lane 0 smallest |
| b_last | input | 1 | Right block is the final one of its stream |
| out_valid | output | 1 | Output beat valid |
| out_ready | input | 1 | Downstream takes the beat |
| out_data | output | W*KW | W ascending merged keys, lane 0 smallest |
| out_last | output | 1 | Final beat of the merge |

## Verification
The merge is driven with streams whose keys interleave one for one, with one side lying wholly below the other in each direction, with all keys equal, with the all-ones maximum key on both sides, and with unequal stream lengths. Interleaving exercises every uneven split of the winners across the sorting network. Disjoint ranges make one side give up all W keys per iteration. Equal and all-ones keys separate real keys from empty slots. Unequal lengths test the point where one side finishes and its slots act as maxima. Some runs stall the output in a repeating pattern, which tests that beats are held and not lost. One run keeps the right side empty while the output is blocked, which tests refill limits and the wait before an iteration.

// File: rtl/merge_pkg.sv
package merge_pkg;

  // Key extended with a high "empty" bit, so unsigned compare ranks empties last.
  function automatic logic [64:0] tag_key(input logic [63:0] key, input logic empty);
    return empty ? {1'b1, 64'd0} : {1'b0, key};
  endfunction

  // Pair decision: left wins on equality.
  function automatic logic left_wins(input logic [64:0] l, input logic [64:0] r);
    return l <= r;
  endfunction

  // Pending keys after an iteration.
  function automatic int unsigned remain(input int unsigned cnt, input int unsigned taken);
    return (taken > cnt) ? 0 : cnt - taken;
  endfunction

endpackage

// File: rtl/merge_lane.sv
module merge_lane #(
  parameter int W  = 4,
  parameter int KW = 64,
  localparam int D  = 2 * W,
  localparam int CW = $clog2(D + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [W*KW-1:0]   in_data,
  input  logic              in_last,
  input  logic              step,
  input  logic [CW-1:0]     take,
  input  logic              clear,
  output logic [D*KW-1:0]   ent,
  output logic [CW-1:0]     cnt,
  output logic              done
);
  import merge_pkg::*;

  logic [KW-1:0] mem_q [D];
  logic [KW-1:0] mem_d [D];
  logic [CW-1:0] cnt_q, cnt_d, taken, base;
  logic          done_q, accept;

  assign in_ready = !done_q && (int'(cnt_q) <= W);
  assign accept   = in_valid && in_ready;
  assign taken    = step ? take : '0;
  assign base     = CW'(remain(int'(cnt_q), int'(taken)));
  assign cnt_d    = base + (accept ? CW'(W) : '0);

  always_comb begin
    for (int i = 0; i < D; i++) begin
      mem_d[i] = mem_q[i];
      for (int s = 0; s <= W; s++) begin
        if (int'(taken) == s && i + s < D) mem_d[i] = mem_q[i + s];
      end
      for (int b = 0; b < W; b++) begin
        if (accept && i == int'(base) + b) mem_d[i] = in_data[b*KW +: KW];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      done_q <= 1'b0;
      for (int i = 0; i < D; i++) mem_q[i] <= '0;
    end else begin
      cnt_q <= cnt_d;
      for (int i = 0; i < D; i++) mem_q[i] <= mem_d[i];
      if (step && clear)             done_q <= 1'b0;
      else if (accept && in_last)    done_q <= 1'b1;
    end
  end

  always_comb begin
    for (int i = 0; i < D; i++) ent[i*KW +: KW] = mem_q[i];
  end
  assign cnt  = cnt_q;
  assign done = done_q;

endmodule

// File: rtl/merge_pick.sv
module merge_pick #(
  parameter int W  = 4,
  parameter int KW = 64,
  localparam int D  = 2 * W,
  localparam int CW = $clog2(D + 1)
) (
  input  logic [D*KW-1:0]      ent_l,
  input  logic [CW-1:0]        cnt_l,
  input  logic [D*KW-1:0]      ent_r,
  input  logic [CW-1:0]        cnt_r,
  output logic [W-1:0][KW:0]   win,
  output logic [CW-1:0]        take_l,
  output logic [CW-1:0]        take_r
);
  import merge_pkg::*;

  always_comb begin
    logic [64:0] lk, rk;
    logic        le, re;
    take_l = '0;
    take_r = '0;
    for (int x = 0; x < W; x++) begin
      le = (x >= int'(cnt_l));
      re = ((W - 1 - x) >= int'(cnt_r));
      lk = tag_key(64'(ent_l[x*KW +: KW]), le);
      rk = tag_key(64'(ent_r[(W-1-x)*KW +: KW]), re);
      if (left_wins(lk, rk)) begin
        win[x] = {lk[64], lk[KW-1:0]};
        if (!le) take_l = take_l + 1'b1;
      end else begin
        win[x] = {rk[64], rk[KW-1:0]};
        if (!re) take_r = take_r + 1'b1;
      end
    end
  end

endmodule

// File: rtl/merge_sortnet.sv
module merge_sortnet #(
  parameter int W  = 4,
  parameter int KW = 64
) (
  input  logic [W-1:0][KW:0] din,
  output logic [W-1:0][KW:0] dout
);
  // Odd-even transposition network: W stages of neighbour compare-swaps.
  for (genvar s = 0; s < W; s++) begin : g_st
    logic [W-1:0][KW:0] src, v;
    if (s == 0) begin : g_first
      assign src = din;
    end else begin : g_next
      assign src = g_st[s-1].v;
    end
    always_comb begin
      v = src;
      for (int i = s % 2; i + 1 < W; i += 2) begin
        if (src[i] > src[i+1]) begin
          v[i]   = src[i+1];
          v[i+1] = src[i];
        end
      end
    end
  end

  assign dout = g_st[W-1].v;

endmodule

// File: rtl/merge_node.sv
module merge_node #(
  parameter int W  = 4,
  parameter int KW = 64,
  localparam int D  = 2 * W,
  localparam int CW = $clog2(D + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            a_valid,
  output logic            a_ready,
  input  logic [W*KW-1:0] a_data,
  input  logic            a_last,
  input  logic            b_valid,
  output logic            b_ready,
  input  logic [W*KW-1:0] b_data,
  input  logic            b_last,
  output logic            out_valid,
  input  logic            out_ready,
  output logic [W*KW-1:0] out_data,
  output logic            out_last
);

  logic [D*KW-1:0]    ent_l, ent_r;
  logic [CW-1:0]      cnt_l, cnt_r, take_l, take_r;
  logic               done_l, done_r;
  logic [W-1:0][KW:0] win, sorted;
  logic               go_w, fire_w, last_w;
  logic               ov_q, ol_q;
  logic [W*KW-1:0]    od_q;

  assign go_w   = (int'(cnt_l) >= W || done_l) && (int'(cnt_r) >= W || done_r)
                  && (cnt_l != '0 || cnt_r != '0);
  assign fire_w = go_w && (!ov_q || out_ready);
  assign last_w = done_l && done_r && (take_l == cnt_l) && (take_r == cnt_r);

  merge_lane #(.W(W), .KW(KW)) u_left (
    .clk(clk), .rst_n(rst_n),
    .in_valid(a_valid), .in_ready(a_ready), .in_data(a_data), .in_last(a_last),
    .step(fire_w), .take(take_l), .clear(last_w),
    .ent(ent_l), .cnt(cnt_l), .done(done_l)
  );

  merge_lane #(.W(W), .KW(KW)) u_right (
    .clk(clk), .rst_n(rst_n),
    .in_valid(b_valid), .in_ready(b_ready), .in_data(b_data), .in_last(b_last),
    .step(fire_w), .take(take_r), .clear(last_w),
    .ent(ent_r), .cnt(cnt_r), .done(done_r)
  );

  merge_pick #(.W(W), .KW(KW)) u_pick (
    .ent_l(ent_l), .cnt_l(cnt_l), .ent_r(ent_r), .cnt_r(cnt_r),
    .win(win), .take_l(take_l), .take_r(take_r)
  );

  merge_sortnet #(.W(W), .KW(KW)) u_sort (.din(win), .dout(sorted));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ov_q <= 1'b0;
      ol_q <= 1'b0;
      od_q <= '0;
    end else if (fire_w) begin
      ov_q <= 1'b1;
      ol_q <= last_w;
      for (int i = 0; i < W; i++) od_q[i*KW +: KW] <= sorted[i][KW-1:0];
    end else if (out_ready) begin
      ov_q <= 1'b0;
    end
  end

  assign out_valid = ov_q;
  assign out_data  = od_q;
  assign out_last  = ol_q;

endmodule

// File: rtl/merge_node_chk.sv
module merge_node_chk #(
  parameter int W  = 4,
  parameter int KW = 64,
  localparam int D  = 2 * W,
  localparam int CW = $clog2(D + 1)
) (
  input logic            clk,
  input logic            rst_n,
  input logic            a_valid,
  input logic            a_ready,
  input logic            b_valid,
  input logic            b_ready,
  input logic            out_valid,
  input logic            out_ready,
  input logic [W*KW-1:0] out_data,
  input logic            out_last,
  input logic            fire,
  input logic            last,
  input logic [CW-1:0]   cnt_l,
  input logic [CW-1:0]   cnt_r,
  input logic [CW-1:0]   take_l,
  input logic [CW-1:0]   take_r
);

  // R2
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    int'(cnt_l) <= D && int'(cnt_r) <= D);

  // R2
  accept_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (a_valid && a_ready) |=> int'(cnt_l) >= W);

  // R6
  full_beat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fire |-> (int'(take_l) + int'(take_r) == W));

  // R7
  last_drain_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && last) |=> (cnt_l == '0 && cnt_r == '0 && a_ready && b_ready));

  // R8
  out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_last)));

  // R4
  for (genvar i = 0; i + 1 < W; i++) begin : g_ord
    lane_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> out_data[i*KW +: KW] <= out_data[(i+1)*KW +: KW]);
  end

endmodule

bind merge_node merge_node_chk #(.W(W), .KW(KW)) u_chk (
  .clk(clk), .rst_n(rst_n),
  .a_valid(a_valid), .a_ready(a_ready), .b_valid(b_valid), .b_ready(b_ready),
  .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data), .out_last(out_last),
  .fire(fire_w), .last(last_w), .cnt_l(cnt_l), .cnt_r(cnt_r),
  .take_l(take_l), .take_r(take_r)
);

// File: tb/test_merge_node.sv
module test_merge_node;
  localparam int W  = 4;
  localparam int KW = 16;
  localparam int MAXK = 6 * W;

  typedef struct packed {
    int        nl;
    int        nr;
    logic [15:0] bl;
    logic [15:0] sl;
    logic [15:0] br;
    logic [15:0] sr;
    int        hold;
    int        stall;
  } scn_t;

  // blocks left/right, key = base + step*index, output hold cycles, stall pattern
  localparam scn_t TBL [8] = '{
    '{2, 2, 16'd0,      16'd2, 16'd1,      16'd2,    0, 0},  // interleaved
    '{2, 2, 16'd0,      16'd1, 16'd100,    16'd1,    0, 1},  // left below right
    '{1, 3, 16'd500,    16'd3, 16'd0,      16'd1,    0, 1},  // right below left, uneven
    '{3, 1, 16'd5,      16'd0, 16'd5,      16'd0,    0, 1},  // all duplicates
    '{2, 2, 16'hFFFF,   16'd0, 16'd10,     16'd1000, 0, 0},  // max keys vs small
    '{3, 2, 16'd7,      16'd5, 16'd3,      16'd11,   0, 1},  // overlapping, uneven
    '{1, 1, 16'hFFFF,   16'd0, 16'hFFFF,   16'd0,    0, 1},  // all max
    '{3, 1, 16'd20,     16'd1, 16'd22,     16'd2,    8, 0}   // held output, right late
  };

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic            rst_n;
  logic            a_valid, a_ready, a_last, b_valid, b_ready, b_last;
  logic [W*KW-1:0] a_data, b_data, out_data;
  logic            out_valid, out_ready, out_last;

  int total = 0;
  int bad   = 0;
  logic [KW-1:0] got [MAXK];
  logic [KW-1:0] expv [MAXK];

  merge_node #(.W(W), .KW(KW)) i_merge_node (
    .clk(clk), .rst_n(rst_n),
    .a_valid(a_valid), .a_ready(a_ready), .a_data(a_data), .a_last(a_last),
    .b_valid(b_valid), .b_ready(b_ready), .b_data(b_data), .b_last(b_last),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data), .out_last(out_last)
  );

  task automatic check(input bit ok, input string req, input longint act, input longint expd);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expd);
    end
  endtask

  function automatic logic [KW-1:0] kv(input logic [15:0] b, input logic [15:0] s, input int i);
    return KW'(b + s * 16'(i));
  endfunction

  task automatic drive_a(input int n, input logic [15:0] b, input logic [15:0] s);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      a_valid = 1'b1;
      a_last  = (k == n - 1);
      for (int j = 0; j < W; j++) a_data[j*KW +: KW] = kv(b, s, k * W + j);
      while (!a_ready) @(negedge clk);
    end
    @(negedge clk);
    a_valid = 1'b0;
  endtask

  task automatic drive_b(input int n, input logic [15:0] b, input logic [15:0] s, input int dly);
    repeat (dly) @(negedge clk);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      b_valid = 1'b1;
      b_last  = (k == n - 1);
      for (int j = 0; j < W; j++) b_data[j*KW +: KW] = kv(b, s, k * W + j);
      while (!b_ready) @(negedge clk);
    end
    @(negedge clk);
    b_valid = 1'b0;
  endtask

  task automatic collect(input scn_t t, input int nexp, output int nk);
    int cyc = 0;
    bit fin = 0;
    bit stalled = 0;
    logic [W*KW-1:0] held = '0;
    logic            held_last = 1'b0;
    nk = 0;
    while (!fin) begin
      @(negedge clk);
      if (stalled)  // R8
        check(out_valid && out_data == held && out_last == held_last,
              "R8 held beat", longint'(out_data[KW-1:0]), longint'(held[KW-1:0]));
      if (cyc < t.hold)        out_ready = 1'b0;
      else if (t.stall != 0)   out_ready = ((cyc % 3) != 2);
      else                     out_ready = 1'b1;
      if (t.hold > 0 && cyc == t.hold - 1) begin
        check(!a_ready, "R2 left full", longint'(a_ready), 0);
        check(!out_valid, "R3 wait for right", longint'(out_valid), 0);
      end
      if (out_valid && out_ready) begin
        for (int j = 0; j + 1 < W; j++)  // R4
          check(out_data[j*KW +: KW] <= out_data[(j+1)*KW +: KW], "R4 lane order",
                longint'(out_data[j*KW +: KW]), longint'(out_data[(j+1)*KW +: KW]));
        check(out_last == (nk + W >= nexp), "R7 last flag", longint'(out_last),
              longint'(nk + W >= nexp));
        for (int j = 0; j < W; j++) begin
          if (nk < MAXK) got[nk] = out_data[j*KW +: KW];
          nk++;
        end
        if (out_last || nk >= nexp + W) fin = 1;
      end
      stalled   = out_valid && !out_ready;
      held      = out_data;
      held_last = out_last;
      cyc++;
    end
  endtask

  task automatic run_scn(input int id, input scn_t t);
    int nexp;
    int nk;
    logic [KW-1:0] tmp;
    nexp = (t.nl + t.nr) * W;
    for (int i = 0; i < t.nl * W; i++) expv[i] = kv(t.bl, t.sl, i);
    for (int i = 0; i < t.nr * W; i++) expv[t.nl * W + i] = kv(t.br, t.sr, i);
    for (int i = 1; i < nexp; i++) begin
      for (int j = i; j > 0; j--) begin
        if (expv[j-1] > expv[j]) begin
          tmp = expv[j]; expv[j] = expv[j-1]; expv[j-1] = tmp;
        end
      end
    end
    fork
      drive_a(t.nl, t.bl, t.sl);
      drive_b(t.nr, t.br, t.sr, t.hold);
      collect(t, nexp, nk);
    join
    check(nk == nexp, "R6 key count", nk, nexp);
    for (int i = 0; i < nexp && i < nk; i++)  // R5
      check(got[i] == expv[i], $sformatf("R5 scenario %0d key %0d", id, i),
            longint'(got[i]), longint'(expv[i]));
    @(negedge clk);
    check(a_ready && b_ready, "R9 ready for next merge", longint'({a_ready, b_ready}), 3);
    out_ready = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    a_valid = 1'b0; a_last = 1'b0; a_data = '0;
    b_valid = 1'b0; b_last = 1'b0; b_data = '0;
    out_ready = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1
    check(!out_valid, "R1 out_valid", longint'(out_valid), 0);
    check(a_ready, "R1 a_ready", longint'(a_ready), 1);
    check(b_ready, "R1 b_ready", longint'(b_ready), 1);
    for (int s = 0; s < 8; s++) run_scn(s, TBL[s]);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule